// File: doc/BRIEF.md
# LCD Sync and Data-Enable Timing Generator

This block produces the line and frame timing for a 320x240 TFT panel that is fed through a narrow parallel port. Depending on the port width and the colour format, one pixel takes one, two or three port clocks. Every horizontal count is therefore expressed in port-clock ticks and scales with that factor. The block drives active-low line and frame sync pulses. It also drives a data-request strobe that marks the ticks on which pixel data must sit on the port, and it exposes its tick and line counters so a neighbouring fetch and packing datapath can follow the raster.

The data window opens at a fixed pixel offset from the line sync. An extra per-mode correction is added to that offset to cover the pipeline latency of the external byte packer. A frame has 240 visible lines. There are two blanking lines before them and two after them. The pixel mode is sampled only at frame boundaries or while the block is disabled, so a frame is never built from two different modes.

Top module: `lcd_sync_gen`

## Requirements
- R1: `mode` selects ticks per pixel (cpp) and a start correction (cor). Value 0 gives cpp 1 and cor 0 (16-bit port, RGB565). Value 1 gives cpp 2 and cor 3 (8-bit port, RGB565). Value 2 gives cpp 3 and cor 5 (8-bit port, RGB888).
- R2: `tick_cnt` counts 0 to 336*cpp-1 within a line and then returns to 0.
- R3: `hsync_n` is low for exactly the first 2*cpp ticks of every line (tick_cnt below 2*cpp) and high otherwise.
- R4: `line_cnt` counts the lines of a frame, 0 to 243 by default (V_PRE + V_ACTIVE + V_POST - 1), and returns to 0 after the last tick of the last line.
- R5: `vsync_n` is low only on line 0 during its first 2*cpp ticks.
- R6: On a visible line, `data_req` is high from tick 7*cpp+cor for 320*cpp consecutive ticks.
- R7: `data_req` is high only on lines V_PRE to V_PRE+V_ACTIVE-1 (lines 2 to 241 by default).
- R8: While `en` is low, both counters read 0, both syncs are high and `data_req` is low. In the first cycle after `en` is seen high, the outputs show line 0, tick 0, and both sync pulses begin.
- R9: A change on `mode` takes effect only after the last tick of a frame, or while `en` is low.
- R10: `mode` value 3 behaves exactly like value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | port clock |
| rst_n | input | 1 | asynchronous active-low reset |
| en | input | 1 | run enable; low clears and idles the raster |
| mode | input | 2 | pixel mode select (R1) |
| hsync_n | output | 1 | active-low line sync |
| vsync_n | output | 1 | active-low frame sync |
| data_req | output | 1 | pixel data wanted on this tick |
| line_cnt | output | LW | current line in frame |
| tick_cnt | output | HW | current tick in line |

## Verification
The bench sweeps every mode. Its most telling checks are the first and last data ticks in the longest mode: a missing pipeline correction shifts the window by 3 or 5 ticks, and a wrong cpp product makes the line period or window width disagree with the model on the very first line. The bench also switches the mode in the middle of a frame. A design that samples the mode continuously changes its line length in that frame and loses the tick count. The enable is dropped mid-line to show that the restart lands on line 0 tick 0 with both syncs low. A design that resumes the old count, or that holds the sync high for one cycle, differs on that first cycle. Mode 3 is run for a whole frame to confirm that it falls back to the one-tick timing.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int H_ACTIVE = 320,
  parameter int H_TOTAL  = 336,
  parameter int H_SYNC   = 2,
  parameter int H_LEAD   = 7,
  parameter int V_ACTIVE = 240,
  parameter int V_PRE    = 2,
  parameter int V_POST   = 2,
  localparam int V_TOTAL = V_PRE + V_ACTIVE + V_POST,
  localparam int HW      = $clog2(H_TOTAL * 3),
  localparam int LW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          data_req,
  output logic [LW-1:0] line_cnt,
  output logic [HW-1:0] tick_cnt
);

  logic          run;
  logic [1:0]    cur_mode;
  logic [HW-1:0] h;
  logic [LW-1:0] v;
  logic [1:0]    cpp;
  logic [2:0]    cor;

  always_comb begin
    case (cur_mode)
      2'd1:    begin cpp = 2'd2; cor = 3'd3; end
      2'd2:    begin cpp = 2'd3; cor = 3'd5; end
      default: begin cpp = 2'd1; cor = 3'd0; end
    endcase
  end

  logic [HW-1:0] h_last, h_sync_end, h_first, h_end;
  assign h_last     = HW'(H_TOTAL * cpp - 1);
  assign h_sync_end = HW'(H_SYNC * cpp);
  assign h_first    = HW'(H_LEAD * cpp + cor);
  assign h_end      = HW'(H_LEAD * cpp + cor + H_ACTIVE * cpp);

  logic line_end, frame_end;
  assign line_end  = (h == h_last);
  assign frame_end = line_end && (v == LW'(V_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cur_mode <= 2'd0;
      h        <= '0;
      v        <= '0;
    end else if (!en) begin
      run      <= 1'b0;
      cur_mode <= mode;
      h        <= '0;
      v        <= '0;
    end else if (!run) begin
      run <= 1'b1;
    end else if (line_end) begin
      h <= '0;
      if (frame_end) begin
        v        <= '0;
        cur_mode <= mode;
      end else begin
        v <= v + 1'b1;
      end
    end else begin
      h <= h + 1'b1;
    end
  end

  logic in_sync, vis_line;
  assign in_sync  = run && (h < h_sync_end);
  assign vis_line = (v >= LW'(V_PRE)) && (v < LW'(V_PRE + V_ACTIVE));

  assign hsync_n  = !in_sync;
  assign vsync_n  = !(in_sync && v == '0);
  assign data_req = run && vis_line && (h >= h_first) && (h < h_end);
  assign line_cnt = v;
  assign tick_cnt = h;

  assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && line_end) |=> (tick_cnt == '0));
  assert_sync_at_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> (tick_cnt == '0));
  assert_vsync_inside_hsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !hsync_n);
  assert_req_outside_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> (hsync_n && vsync_n));
  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hsync_n && vsync_n && !data_req && line_cnt == '0 && tick_cnt == '0));
  assert_mode_held_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && !frame_end) |=> $stable(cur_mode));

endmodule

// File: tb/sim_lcd_sync_gen.sv
module sim_lcd_sync_gen;
  localparam int VA = 8, VP = 2, VQ = 2, VT = VA + VP + VQ;
  localparam int HW = $clog2(336 * 3), LW = $clog2(VT);

  logic clk = 0, rst_n = 0, en = 0;
  logic [1:0] mode = 0;
  logic hsync_n, vsync_n, data_req;
  logic [LW-1:0] line_cnt;
  logic [HW-1:0] tick_cnt;

  always #4 clk = ~clk;

  lcd_sync_gen #(.V_ACTIVE(VA), .V_PRE(VP), .V_POST(VQ)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .data_req(data_req),
    .line_cnt(line_cnt), .tick_cnt(tick_cnt));

  int checks = 0, fails = 0, cycles = 0;
  int m_run = 0, m_mode = 0, m_h = 0, m_v = 0;

  function automatic int cpp_of(int m); return (m == 1) ? 2 : (m == 2) ? 3 : 1; endfunction
  function automatic int cor_of(int m); return (m == 1) ? 3 : (m == 2) ? 5 : 0; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run <= 0; m_mode <= 0; m_h <= 0; m_v <= 0;
    end else if (!en) begin
      m_run <= 0; m_mode <= mode; m_h <= 0; m_v <= 0;
    end else if (!m_run) begin
      m_run <= 1;
    end else if (m_h == 336 * cpp_of(m_mode) - 1) begin
      m_h <= 0;
      if (m_v == VT - 1) begin m_v <= 0; m_mode <= mode; end
      else m_v <= m_v + 1;
    end else m_h <= m_h + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  int req_start = 0, req_len = 0;
  logic prev_req = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int c, st, e_hs, e_vs, e_dr;
      c  = cpp_of(m_mode);
      st = 7 * c + cor_of(m_mode);
      e_hs = !(m_run && m_h < 2 * c);
      e_vs = !(m_run && m_v == 0 && m_h < 2 * c);
      e_dr = m_run && m_v >= VP && m_v < VP + VA && m_h >= st && m_h < st + 320 * c;
      chk(int'(tick_cnt) == m_h, "R2 tick_cnt", int'(tick_cnt), m_h);
      chk(int'(line_cnt) == m_v, "R4 line_cnt", int'(line_cnt), m_v);
      chk(int'(hsync_n) == e_hs, "R3 hsync_n", int'(hsync_n), e_hs);
      chk(int'(vsync_n) == e_vs, "R5 vsync_n", int'(vsync_n), e_vs);
      chk(int'(data_req) == e_dr, "R7 data_req", int'(data_req), e_dr);
      if (data_req && !prev_req) begin
        req_start = int'(tick_cnt); req_len = 0;
        chk(req_start == st, "R1 R6 window start", req_start, st);
      end
      if (data_req) req_len++;
      if (!data_req && prev_req)
        chk(req_len == 320 * c, "R6 window length", req_len, 320 * c);
      prev_req = data_req;
    end
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic ticks(int n); repeat (n) @(negedge clk); endtask

  initial begin
    ticks(3);
    chk(hsync_n && vsync_n && !data_req && tick_cnt == 0 && line_cnt == 0,
        "R8 reset idle", int'({hsync_n, vsync_n, data_req}), 6);
    rst_n = 1;
    ticks(2);
    en = 1; mode = 0;
    ticks(336 * VT / 2);
    mode = 2;                      // R9: mid-frame change must wait
    ticks(336 * VT / 2 + 1008 * VT * 2);
    mode = 1;
    ticks(1008 * VT + 672 * VT);
    en = 0; mode = 3;              // R8 mid-line drop, R10 mode 3
    ticks(5);
    chk(hsync_n && vsync_n && !data_req && tick_cnt == 0,
        "R8 disabled idle", int'(tick_cnt), 0);
    en = 1;
    ticks(1);
    chk(!hsync_n && !vsync_n && tick_cnt == 0 && line_cnt == 0,
        "R8 restart at line 0", int'({hsync_n, vsync_n}), 0);
    ticks(336 * VT + 10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule